// File: doc/BRIEF.md
# Accumulator Arithmetic/Logic Datapath

This block is the operating half of a small single-level processor. It keeps one operand in a temporary register and the other in an accumulator. A combinational adder/logic unit feeds a post-shifter, and the shifted result is written back into the accumulator in place; there is no separate result register. The accumulator sits on the internal data bus through a bidirectional port. It drives the bus when asked and loads from it otherwise. A flags register keeps zero, negative, carry and overflow of the last written result, so that an external sequencer can branch on them.

The sequencer drives one strobe per micro-operation, and all state changes on the next rising clock edge. Compatible strobes may be raised in the same cycle, for example a temporary-register load together with an accumulator operation. At most one accumulator action takes effect per cycle. A combinational decoder picks it from the named actions HOLD, CLEAR, LOAD, RESULT, INC and DEC. The priority runs CLEAR, then LOAD, then RESULT, then INC, then DEC, and HOLD applies when no accumulator strobe is raised. The state register moves from its current value to the value of the chosen action on every edge, and returns to zero on reset.

Top module: `acc_datapath`

## Requirements
- R1: While `rst_n` is low, the accumulator, the temporary register and all four flags are cleared to zero, asynchronously.
- R2: The accumulator drives `data_bus` only in cycles where `acc_oe` is 1. When `acc_oe` is 0 the port is high-impedance, so any other bus driver is seen undisturbed.
- R3: `acc_clear` loads zero and `acc_load` loads the bus value. The accumulator action priority is clear > load > ALU result > increment > decrement, so load wins over a simultaneous increment.
- R4: `acc_inc` and `acc_dec` add or subtract one modulo 256, and they leave the flags unchanged.
- R5: With `alu_go` and `alu_op`=0 (add), the result is acc + B + `carry_in`, where B is the temporary register, or its bitwise inverse when `inv_operand` is 1. Subtraction is add with `inv_operand`=1 and `carry_in`=1.
- R6: `alu_op` codes: 1 = AND, 2 = OR, 3 = XOR (acc with B), 4 = move B into the accumulator, 5 to 7 = pass the accumulator unchanged (test).
- R7: `tmp_load` loads the temporary register from the bus. Otherwise `tmp_invert` replaces it with its bitwise inverse.
- R8: With `shift_en`, the ALU result is shifted by one place before write-back, to the right when `shift_right`=1. A logical shift moves all 8 bits and fills with 0. An arithmetic shift (`shift_arith`=1) keeps bit 7, moves only bits 6..0 and fills the vacated magnitude bit with 0.
- R9: Flags are written only when the ALU result is written to the accumulator. Zero and negative (bit 7) come from the shifted result. Carry is the adder carry-out and overflow is two's-complement overflow of the add; both are 0 for every other op code.
- R10: Each micro-operation completes in one clock. Strobes raised together in one cycle all act on the register values from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| data_bus | inout | 8 | Internal data bus, bidirectional |
| acc_oe | input | 1 | Accumulator drives the bus |
| acc_load | input | 1 | Load accumulator from bus |
| acc_clear | input | 1 | Clear accumulator |
| acc_inc | input | 1 | Increment accumulator |
| acc_dec | input | 1 | Decrement accumulator |
| tmp_load | input | 1 | Load temporary register from bus |
| tmp_invert | input | 1 | Invert temporary register |
| alu_go | input | 1 | Write ALU/shifter result to accumulator |
| alu_op | input | 3 | ALU operation code |
| inv_operand | input | 1 | Use inverted temporary register as B |
| carry_in | input | 1 | Adder carry input |
| shift_en | input | 1 | Apply one-place shift to the result |
| shift_right | input | 1 | Shift direction, 1 = right |
| shift_arith | input | 1 | Arithmetic (sign-keeping) shift |
| flag_zero | output | 1 | Result was zero |
| flag_neg | output | 1 | Result bit 7 |
| flag_carry | output | 1 | Adder carry-out |
| flag_ovf | output | 1 | Two's-complement overflow |

## Verification
The bench targets the adds that set overflow without carry (0x7F+1) and carry with a zero result (0xFF+1). A swapped or missing carry/overflow rule shows up there as wrong flag bits. Sign-keeping shifts on 0x81 and 0xC1 expose a shifter that moves or duplicates bit 7. A logical right shift that fills with the sign bit reads back 0xC0 instead of 0x40. Load together with increment and a temporary-register load together with an add check the priority and that same-cycle strobes see the old values. Increment wrap and flag retention catch a design that updates flags on increment. Random strobe mixes are compared against a bench model throughout.

// File: rtl/acc_dp_pkg.sv
package acc_dp_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 3'd0,
        OP_AND  = 3'd1,
        OP_OR   = 3'd2,
        OP_XOR  = 3'd3,
        OP_MOVE = 3'd4,
        OP_TST5 = 3'd5,
        OP_TST6 = 3'd6,
        OP_TST7 = 3'd7
    } alu_op_e;

    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_CLEAR,
        ACT_LOAD,
        ACT_RESULT,
        ACT_INC,
        ACT_DEC
    } acc_act_e;

endpackage

// File: rtl/acc_dp_arith.sv
module acc_dp_arith
    import acc_dp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb_raw,
    input  logic         inv_b,
    input  logic         cin,
    input  alu_op_e      op,
    output logic [W-1:0] res,
    output logic         cout,
    output logic         ovf
);
    localparam int MSB = W - 1;

    logic [W-1:0] opb;
    logic [W:0]   sum;

    always_comb begin
        opb  = inv_b ? ~opb_raw : opb_raw;
        sum  = {1'b0, opa} + {1'b0, opb} + {{W{1'b0}}, cin};
        cout = 1'b0;
        ovf  = 1'b0;
        unique case (op)
            OP_ADD: begin
                res  = sum[W-1:0];
                cout = sum[W];
                ovf  = (opa[MSB] == opb[MSB]) && (sum[MSB] != opa[MSB]);
            end
            OP_AND:  res = opa & opb;
            OP_OR:   res = opa | opb;
            OP_XOR:  res = opa ^ opb;
            OP_MOVE: res = opb;
            OP_TST5, OP_TST6, OP_TST7: res = opa;
        endcase
    end

    // R9: only the add produces carry or overflow
    always_comb begin
        if (op != OP_ADD) begin
            assert_logic_no_carry_R9: assert (!cout && !ovf);
        end
    end

endmodule

// File: rtl/acc_dp_shifter.sv
module acc_dp_shifter #(
    parameter int W = 8
) (
    input  logic [W-1:0] din,
    input  logic         en,
    input  logic         right,
    input  logic         arith,
    output logic [W-1:0] dout
);
    localparam int MSB = W - 1;

    logic [W-1:0] lsl, lsr, asl, asr;

    always_comb begin
        lsl = {din[MSB-1:0], 1'b0};
        lsr = {1'b0, din[MSB:1]};
        asl = {din[MSB], din[MSB-2:0], 1'b0};
        asr = {din[MSB], 1'b0, din[MSB-1:1]};
        unique case ({en, arith, right})
            3'b100:  dout = lsl;
            3'b101:  dout = lsr;
            3'b110:  dout = asl;
            3'b111:  dout = asr;
            default: dout = din;
        endcase
    end

    // R8: arithmetic shift keeps the sign bit in place
    always_comb begin
        if (en && arith) begin
            assert_sign_kept_R8: assert (dout[MSB] == din[MSB]);
        end
    end

endmodule

// File: rtl/acc_dp_flags.sv
module acc_dp_flags #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd,
    input  logic [W-1:0] res,
    input  logic         cout,
    input  logic         ovf,
    output logic         z,
    output logic         n,
    output logic         c,
    output logic         v
);
    localparam int MSB = W - 1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            z <= 1'b0;
            n <= 1'b0;
            c <= 1'b0;
            v <= 1'b0;
        end else if (upd) begin
            z <= (res == '0);
            n <= res[MSB];
            c <= cout;
            v <= ovf;
        end
    end

    assert_flags_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable({z, n, c, v}));

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
    import acc_dp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    inout  wire  [W-1:0] data_bus,
    input  logic         acc_oe,
    input  logic         acc_load,
    input  logic         acc_clear,
    input  logic         acc_inc,
    input  logic         acc_dec,
    input  logic         tmp_load,
    input  logic         tmp_invert,
    input  logic         alu_go,
    input  logic [2:0]   alu_op,
    input  logic         inv_operand,
    input  logic         carry_in,
    input  logic         shift_en,
    input  logic         shift_right,
    input  logic         shift_arith,
    output logic         flag_zero,
    output logic         flag_neg,
    output logic         flag_carry,
    output logic         flag_ovf
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] acc_q, tmp_q;
    logic [W-1:0] alu_res, shf_res;
    logic         alu_cout, alu_ovf;
    acc_act_e     act;

    // R2: tri-state drive of the shared bus
    assign data_bus = acc_oe ? acc_q : {W{1'bz}};

    // accumulator action decode, fixed priority (R3)
    always_comb begin
        if (acc_clear)     act = ACT_CLEAR;
        else if (acc_load) act = ACT_LOAD;
        else if (alu_go)   act = ACT_RESULT;
        else if (acc_inc)  act = ACT_INC;
        else if (acc_dec)  act = ACT_DEC;
        else               act = ACT_HOLD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            unique case (act)
                ACT_HOLD:   acc_q <= acc_q;
                ACT_CLEAR:  acc_q <= '0;
                ACT_LOAD:   acc_q <= data_bus;
                ACT_RESULT: acc_q <= shf_res;
                ACT_INC:    acc_q <= acc_q + ONE;
                ACT_DEC:    acc_q <= acc_q - ONE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          tmp_q <= '0;
        else if (tmp_load)   tmp_q <= data_bus;
        else if (tmp_invert) tmp_q <= ~tmp_q;
    end

    acc_dp_arith #(.W(W)) u_arith (
        .opa     (acc_q),
        .opb_raw (tmp_q),
        .inv_b   (inv_operand),
        .cin     (carry_in),
        .op      (alu_op_e'(alu_op)),
        .res     (alu_res),
        .cout    (alu_cout),
        .ovf     (alu_ovf)
    );

    acc_dp_shifter #(.W(W)) u_shift (
        .din   (alu_res),
        .en    (shift_en),
        .right (shift_right),
        .arith (shift_arith),
        .dout  (shf_res)
    );

    acc_dp_flags #(.W(W)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (act == ACT_RESULT),
        .res   (shf_res),
        .cout  (alu_cout),
        .ovf   (alu_ovf),
        .z     (flag_zero),
        .n     (flag_neg),
        .c     (flag_carry),
        .v     (flag_ovf)
    );

    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_clear |=> (acc_q == '0));

    assert_load_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_load && !acc_clear) |=> (acc_q == $past(data_bus)));

    assert_inc_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_inc && !acc_clear && !acc_load && !alu_go) |=> (acc_q == $past(acc_q) + ONE));

    assert_tmp_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tmp_load |=> (tmp_q == $past(data_bus)));

endmodule

// File: tb/acc_datapath_tb.sv
`timescale 1ns/1ps
module acc_datapath_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_oe = 0, acc_load = 0, acc_clear = 0, acc_inc = 0, acc_dec = 0;
    logic tmp_load = 0, tmp_invert = 0, alu_go = 0;
    logic [2:0] alu_op = 3'd0;
    logic inv_operand = 0, carry_in = 0, shift_en = 0, shift_right = 0, shift_arith = 0;
    logic flag_zero, flag_neg, flag_carry, flag_ovf;
    logic tb_oe = 1'b0;
    logic [7:0] tb_val = 8'h00;
    wire  [7:0] bus;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [7:0] m_acc = 8'h00, m_tmp = 8'h00;
    logic [3:0] m_flg = 4'h0;

    assign bus = tb_oe ? tb_val : 8'hzz;

    always #2 clk = ~clk;

    acc_datapath u_dut (
        .clk(clk), .rst_n(rst_n), .data_bus(bus), .acc_oe(acc_oe),
        .acc_load(acc_load), .acc_clear(acc_clear), .acc_inc(acc_inc), .acc_dec(acc_dec),
        .tmp_load(tmp_load), .tmp_invert(tmp_invert), .alu_go(alu_go), .alu_op(alu_op),
        .inv_operand(inv_operand), .carry_in(carry_in), .shift_en(shift_en),
        .shift_right(shift_right), .shift_arith(shift_arith),
        .flag_zero(flag_zero), .flag_neg(flag_neg), .flag_carry(flag_carry), .flag_ovf(flag_ovf)
    );

    // returns {c, v, result}
    function automatic logic [9:0] model_alu(input logic [7:0] a, input logic [7:0] t,
                                             input logic [2:0] op, input logic inv, input logic ci,
                                             input logic se, input logic sr, input logic sa);
        logic [7:0] b, r, s;
        logic [8:0] sum;
        logic c, v;
        b = inv ? ~t : t;
        c = 1'b0;
        v = 1'b0;
        sum = {1'b0, a} + {1'b0, b} + {8'd0, ci};
        case (op)
            3'd0: begin r = sum[7:0]; c = sum[8]; v = (a[7] == b[7]) && (r[7] != a[7]); end
            3'd1: r = a & b;
            3'd2: r = a | b;
            3'd3: r = a ^ b;
            3'd4: r = b;
            default: r = a;
        endcase
        s = r;
        if (se) begin
            if (sa) s = sr ? {r[7], 1'b0, r[6:1]} : {r[7], r[5:0], 1'b0};
            else    s = sr ? {1'b0, r[7:1]} : {r[6:0], 1'b0};
        end
        return {c, v, s};
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] flags_now();
        return {flag_zero, flag_neg, flag_carry, flag_ovf};
    endfunction

    // one operation cycle from the currently driven strobes, then read-back phase
    task automatic step();
        logic [7:0] n_acc, n_tmp, busv;
        logic [3:0] n_flg;
        logic [9:0] r;
        busv  = tb_val;
        n_acc = m_acc;
        n_tmp = m_tmp;
        n_flg = m_flg;
        r = model_alu(m_acc, m_tmp, alu_op, inv_operand, carry_in, shift_en, shift_right, shift_arith);
        if (acc_clear)     n_acc = 8'h00;
        else if (acc_load) n_acc = busv;
        else if (alu_go) begin
            n_acc = r[7:0];
            n_flg = {r[7:0] == 8'h00, r[7], r[9], r[8]};
        end
        else if (acc_inc)  n_acc = m_acc + 8'd1;
        else if (acc_dec)  n_acc = m_acc - 8'd1;
        if (tmp_load)        n_tmp = busv;
        else if (tmp_invert) n_tmp = ~m_tmp;
        @(posedge clk);
        m_acc = n_acc;
        m_tmp = n_tmp;
        m_flg = n_flg;
        @(negedge clk);
        {acc_load, acc_clear, acc_inc, acc_dec, tmp_load, tmp_invert, alu_go} = '0;
        {inv_operand, carry_in, shift_en, shift_right, shift_arith} = '0;
        alu_op = 3'd0;
        tb_oe = 1'b0;
        acc_oe = 1'b1;
        #1;
    endtask

    task automatic load_acc(input logic [7:0] v);
        acc_oe = 0; tb_oe = 1; tb_val = v; acc_load = 1; step();
    endtask

    task automatic load_tmp(input logic [7:0] v);
        acc_oe = 0; tb_oe = 1; tb_val = v; tmp_load = 1; step();
    endtask

    task automatic alu(input logic [2:0] op, input logic inv, input logic ci,
                       input logic se, input logic sr, input logic sa);
        acc_oe = 0; alu_go = 1; alu_op = op; inv_operand = inv; carry_in = ci;
        shift_en = se; shift_right = sr; shift_arith = sa; step();
    endtask

    task automatic chk_model(input string tag);
        chk({tag, " acc"}, bus, m_acc);
        chk({tag, " flags"}, {4'h0, flags_now()}, {4'h0, m_flg});
    endtask

    initial begin
        #400000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] f_before;
        void'($urandom(32'h5EED_0A11));
        repeat (3) @(posedge clk);
        @(negedge clk);
        acc_oe = 1;
        #1;
        // R1: reset state visible at the ports while held in reset
        chk("R1 acc in reset", bus, 8'h00);
        chk("R1 flags in reset", {4'h0, flags_now()}, 8'h00);
        rst_n = 1;
        @(negedge clk);
        #1;

        // R5: subtraction 5 - 3
        load_acc(8'h05); load_tmp(8'h03);
        alu(3'd0, 1, 1, 0, 0, 0);
        chk("R5 sub result", bus, 8'h02);
        chk("R9 sub flags", {4'h0, flags_now()}, 8'h02);

        // R6: AND clears carry
        load_acc(8'hF0); load_tmp(8'h3C);
        alu(3'd1, 0, 0, 0, 0, 0);
        chk("R6 and result", bus, 8'h30);
        chk("R9 and flags", {4'h0, flags_now()}, 8'h00);

        // R9: overflow without carry
        load_acc(8'h7F); load_tmp(8'h01);
        alu(3'd0, 0, 0, 0, 0, 0);
        chk("R9 ovf result", bus, 8'h80);
        chk("R9 ovf flags", {4'h0, flags_now()}, 8'h05);

        // R9: carry with zero result
        load_acc(8'hFF);
        alu(3'd0, 0, 0, 0, 0, 0);
        chk("R9 carry result", bus, 8'h00);
        chk("R9 carry flags", {4'h0, flags_now()}, 8'h0A);

        // R8: shifts through the test op
        load_acc(8'h81);
        alu(3'd5, 0, 0, 1, 1, 1);
        chk("R8 asr", bus, 8'h80);
        chk("R8 asr flags", {4'h0, flags_now()}, 8'h04);
        load_acc(8'hC1);
        alu(3'd6, 0, 0, 1, 0, 1);
        chk("R8 asl", bus, 8'h82);
        load_acc(8'h81);
        alu(3'd7, 0, 0, 1, 1, 0);
        chk("R8 lsr", bus, 8'h40);
        load_acc(8'h81);
        alu(3'd5, 0, 0, 1, 0, 0);
        chk("R8 lsl", bus, 8'h02);

        // R3: load beats increment; clear beats load
        acc_oe = 0; tb_oe = 1; tb_val = 8'h3C; acc_load = 1; acc_inc = 1; step();
        chk("R3 load over inc", bus, 8'h3C);
        acc_oe = 0; tb_oe = 1; tb_val = 8'h77; acc_load = 1; acc_clear = 1; step();
        chk("R3 clear over load", bus, 8'h00);

        // R4: wrap both ways, flags untouched
        f_before = {4'h0, flags_now()};
        acc_oe = 0; acc_dec = 1; step();
        chk("R4 dec wrap", bus, 8'hFF);
        acc_oe = 0; acc_inc = 1; step();
        chk("R4 inc wrap", bus, 8'h00);
        chk("R4 flags kept", {4'h0, flags_now()}, f_before);

        // R7: invert temp, observed through move
        load_tmp(8'h0F);
        acc_oe = 0; tmp_invert = 1; step();
        alu(3'd4, 0, 0, 0, 0, 0);
        chk("R7 tmp invert", bus, 8'hF0);
        alu(3'd4, 1, 0, 0, 0, 0);
        chk("R6 move inverted", bus, 8'h0F);

        // R10: same-cycle temp load and add use the old temp value
        load_acc(8'h22); load_tmp(8'h11);
        acc_oe = 0; tb_oe = 1; tb_val = 8'h99; tmp_load = 1;
        alu_go = 1; alu_op = 3'd0; step();
        chk("R10 old operand", bus, 8'h33);
        alu(3'd4, 0, 0, 0, 0, 0);
        chk("R10 new temp", bus, 8'h99);

        // R2: bus released when output enable is low
        acc_oe = 0; tb_oe = 1; tb_val = 8'h5A;
        #1;
        chk("R2 bus released", bus, 8'h5A);
        tb_oe = 0; acc_oe = 1;
        #1;
        chk("R2 bus driven", bus, 8'h99);

        // random mixes, model checked (R3 R5 R6 R8 R9 R10)
        for (int i = 0; i < 300; i++) begin
            logic [3:0] pick;
            pick = 4'($urandom % 16);
            acc_oe = 0;
            acc_clear  = ($urandom % 20) == 0;
            acc_load   = pick[0] & pick[1];
            tmp_load   = pick[2] & ~pick[3];
            tmp_invert = ($urandom % 4) == 0;
            alu_go     = ($urandom % 3) != 0;
            acc_inc    = ($urandom % 4) == 0;
            acc_dec    = ($urandom % 4) == 0;
            alu_op     = 3'($urandom % 8);
            inv_operand = 1'($urandom % 2);
            carry_in    = 1'($urandom % 2);
            shift_en    = ($urandom % 3) == 0;
            shift_right = 1'($urandom % 2);
            shift_arith = 1'($urandom % 2);
            tb_val = 8'($urandom % 256);
            tb_oe  = acc_load | tmp_load;
            step();
            chk_model("R9 random");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule